// File: doc/BRIEF.md
# Packed SIMD Saturating Arithmetic Unit

This execution unit works on two 64-bit packed words. An element-size input splits each word into eight 8-bit, four 16-bit or two 32-bit lanes. One operation code applies the same operation to every lane at once. The arithmetic operations are add and subtract, each in three forms:

- wrap-around, which keeps the low bits;
- signed saturating;
- unsigned saturating.

A lane-wise equality compare produces lane masks. Whole-word AND, AND-NOT and OR combine those masks with data, so a per-lane select needs no branch.

Inputs are accepted when `in_valid_i` is high. The result appears on `res_o` one clock later, and `valid_o` is high in that cycle. When no input is accepted, the result register keeps its last value. Carries and borrows never cross a lane boundary.

Top module: `simd_sat_unit`

## Requirements
- R1: Element size `esize_i` selects the lane width: 0 means 8 bits, 1 means 16 bits, and 2 or 3 mean 32 bits. Lane k occupies bits [k*w +: w]. No carry or borrow passes from one lane into the next.
- R2: Opcode 0 (add) and opcode 3 (subtract, a minus b) return the low w bits of each lane's sum or difference.
- R3: Opcode 1 (signed saturating add) and opcode 4 (signed saturating subtract) treat lanes as two's complement. Results above 2^(w-1)-1 become 2^(w-1)-1, and results below -2^(w-1) become -2^(w-1).
- R4: Opcode 2 (unsigned saturating add) and opcode 5 (unsigned saturating subtract) treat lanes as unsigned. Results above 2^w-1 become 2^w-1, and results below 0 become 0.
- R5: Opcode 6 (compare-equal) sets every bit of a lane to 1 when the two operand lanes are equal, and every bit to 0 when they differ.
- R6: Opcode 7 returns a AND b, opcode 8 returns (NOT a) AND b, and opcode 9 returns a OR b. All three act on the whole 64-bit word and do not depend on `esize_i`.
- R7: When `in_valid_i` is high at a rising clock edge, `res_o` holds that operation's result and `valid_o` is 1 until the next rising edge.
- R8: Opcodes 10 to 15 give a result of all zeros, and `valid_o` is still asserted.
- R9: While `rst_ni` is low, `valid_o` is 0 and `res_o` is 0.
- R10: After a rising edge with `in_valid_i` low, `valid_o` is 0 and `res_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Accept operands and operation this cycle |
| op_i | input | 4 | Operation code |
| esize_i | input | 2 | Lane width select |
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand |
| res_o | output | 64 | Registered packed result |
| valid_o | output | 1 | Result register loaded in the previous cycle |

## Verification
The lane-level assertions are immediate checks. They assume known operand and opcode values, and they skip any evaluation where an input is unknown. The bench drives every input from time zero, so no such gap arises. The clocked properties assume that `op_i`, `esize_i`, `a_i` and `b_i` stay stable across the accepting edge. The stimulus keeps to this by changing inputs only on the falling edge. The stimulus mixes directed lane-boundary values (0, maximum, sign limits, values with a carry out) with pseudo-random words, for every element size, including the size code that is not listed.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int DW = 64;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_ADD_SS = 4'd1,
    OP_ADD_US = 4'd2,
    OP_SUB    = 4'd3,
    OP_SUB_SS = 4'd4,
    OP_SUB_US = 4'd5,
    OP_CMPEQ  = 4'd6,
    OP_AND    = 4'd7,
    OP_ANDN   = 4'd8,
    OP_OR     = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    ES_8  = 2'd0,
    ES_16 = 2'd1,
    ES_32 = 2'd2
  } esize_e;
endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  op_e          op_i,
  output logic [W-1:0] res_o
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] UMAX = {W{1'b1}};

  logic [W:0] sum, dif;
  logic       s_ovf_add, s_ovf_sub;

  assign sum = {1'b0, a_i} + {1'b0, b_i};
  assign dif = {1'b0, a_i} - {1'b0, b_i};
  assign s_ovf_add = (a_i[W-1] == b_i[W-1]) && (sum[W-1] != a_i[W-1]);
  assign s_ovf_sub = (a_i[W-1] != b_i[W-1]) && (dif[W-1] != a_i[W-1]);

  always_comb begin
    res_o = '0;
    unique case (op_i)
      OP_ADD:    res_o = sum[W-1:0];
      OP_SUB:    res_o = dif[W-1:0];
      OP_ADD_SS: res_o = s_ovf_add ? (a_i[W-1] ? SMIN : SMAX) : sum[W-1:0];
      OP_SUB_SS: res_o = s_ovf_sub ? (a_i[W-1] ? SMIN : SMAX) : dif[W-1:0];
      OP_ADD_US: res_o = sum[W] ? UMAX : sum[W-1:0];
      OP_SUB_US: res_o = dif[W] ? '0 : dif[W-1:0];
      OP_CMPEQ:  res_o = (a_i == b_i) ? UMAX : '0;
      default:   res_o = '0;
    endcase
  end

  // Lane-level sanity checks, skipped while inputs are unknown
  always_comb begin
    if (!$isunknown({a_i, b_i, op_i})) begin
      if (op_i == OP_ADD_US)
        a_r4_us_add_not_below: assert (res_o >= a_i);
      if (op_i == OP_SUB_US)
        a_r4_us_sub_not_above: assert (res_o <= a_i);
      if (op_i == OP_ADD_SS && !a_i[W-1] && !b_i[W-1])
        a_r3_ss_add_pos_stays_pos: assert (!res_o[W-1]);
      if (op_i == OP_ADD_SS && a_i[W-1] && b_i[W-1])
        a_r3_ss_add_neg_stays_neg: assert (res_o[W-1]);
      if (op_i == OP_CMPEQ)
        a_r5_mask_uniform: assert (res_o == '0 || res_o == UMAX);
    end
  end
endmodule

// File: rtl/simd_part_alu.sv
module simd_part_alu
  import simd_pkg::*;
#(
  parameter int DWID = 64,
  parameter int W    = 8
) (
  input  logic [DWID-1:0] a_i,
  input  logic [DWID-1:0] b_i,
  input  op_e             op_i,
  output logic [DWID-1:0] res_o
);
  localparam int NL = DWID / W;

  for (genvar k = 0; k < NL; k++) begin : g_lane
    simd_lane_alu #(.W(W)) u_lane (
      .a_i  (a_i[k*W +: W]),
      .b_i  (b_i[k*W +: W]),
      .op_i (op_i),
      .res_o(res_o[k*W +: W])
    );
  end
endmodule

// File: rtl/simd_bitwise.sv
module simd_bitwise
  import simd_pkg::*;
#(
  parameter int DWID = 64
) (
  input  logic [DWID-1:0] a_i,
  input  logic [DWID-1:0] b_i,
  input  op_e             op_i,
  output logic [DWID-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_ANDN: res_o = ~a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_sat_unit.sv
module simd_sat_unit
  import simd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [3:0]    op_i,
  input  logic [1:0]    esize_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o,
  output logic          valid_o
);
  localparam int NW = 3;

  op_e           op;
  logic [DW-1:0] part_res [NW];
  logic [DW-1:0] logic_res;
  logic [DW-1:0] arith_res;
  logic [DW-1:0] next_res;
  logic          is_arith, is_logic;

  assign op = op_e'(op_i);

  for (genvar g = 0; g < NW; g++) begin : g_width
    simd_part_alu #(.DWID(DW), .W(8 << g)) u_part (
      .a_i  (a_i),
      .b_i  (b_i),
      .op_i (op),
      .res_o(part_res[g])
    );
  end

  simd_bitwise #(.DWID(DW)) u_bitwise (
    .a_i  (a_i),
    .b_i  (b_i),
    .op_i (op),
    .res_o(logic_res)
  );

  always_comb begin
    unique case (esize_i)
      ES_8:    arith_res = part_res[0];
      ES_16:   arith_res = part_res[1];
      default: arith_res = part_res[2];
    endcase
  end

  assign is_arith = (op_i <= 4'd6);
  assign is_logic = (op_i >= 4'd7) && (op_i <= 4'd9);
  assign next_res = is_arith ? arith_res : (is_logic ? logic_res : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= in_valid_i;
      if (in_valid_i) res_o <= next_res;
    end
  end

  a_r7_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> valid_o);
  a_r10_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !valid_o);
  a_r10_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(res_o));
  a_r8_undef_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i >= 4'd10) |=> (res_o == '0));
  a_r6_and_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 4'd7) |=> (res_o == $past(a_i & b_i)));
  a_r6_or_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 4'd9) |=> (res_o == $past(a_i | b_i)));
  a_r5_cmp_self: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 4'd6 && a_i == b_i) |=> (res_o == '1));
endmodule

// File: tb/simd_sat_unit_tb_top.sv
`timescale 1ns/1ps
module simd_sat_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  esize_i = '0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic [63:0] res_o;
  logic        valid_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [63:0] exp_res = '0;
  bit          exp_valid = 0;
  string       exp_tag = "R9";

  always #2.5 clk_i = ~clk_i;

  simd_sat_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .op_i(op_i),
    .esize_i(esize_i), .a_i(a_i), .b_i(b_i), .res_o(res_o), .valid_o(valid_o)
  );

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd3: return "R2";
      4'd1, 4'd4: return "R3";
      4'd2, 4'd5: return "R4";
      4'd6:       return "R5";
      4'd7, 4'd8, 4'd9: return "R6";
      default:    return "R8";
    endcase
  endfunction

  // Behavioural model: per-lane integer arithmetic
  function automatic logic [63:0] model(input logic [3:0] op, input logic [1:0] es,
                                        input logic [63:0] a, input logic [63:0] b);
    int w;
    logic [63:0] r;
    longint mask, half;
    w = (es == 2'd0) ? 8 : (es == 2'd1) ? 16 : 32;
    if (op == 4'd7) return a & b;
    if (op == 4'd8) return ~a & b;
    if (op == 4'd9) return a | b;
    if (op > 4'd9) return 64'd0;
    mask = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    r = '0;
    for (int k = 0; k < 64 / w; k++) begin
      longint ua, ub, sa, sb, v;
      ua = longint'((a >> (k * w)) & 64'(mask));
      ub = longint'((b >> (k * w)) & 64'(mask));
      sa = (ua >= half) ? ua - (mask + 1) : ua;
      sb = (ub >= half) ? ub - (mask + 1) : ub;
      case (op)
        4'd0: v = ua + ub;
        4'd3: v = ua - ub;
        4'd1: begin v = sa + sb; if (v > half - 1) v = half - 1; if (v < -half) v = -half; end
        4'd4: begin v = sa - sb; if (v > half - 1) v = half - 1; if (v < -half) v = -half; end
        4'd2: begin v = ua + ub; if (v > mask) v = mask; end
        4'd5: begin v = ua - ub; if (v < 0) v = 0; end
        default: v = (ua == ub) ? mask : 0;
      endcase
      r = r | ((64'(v) & 64'(mask)) << (k * w));
    end
    return r;
  endfunction

  task automatic check_now();
    total++;
    if (res_o !== exp_res || valid_o !== exp_valid) begin
      bad++;
      $display("FAIL %s: res=%h valid=%b expected res=%h valid=%b",
               exp_tag, res_o, valid_o, exp_res, exp_valid);
    end
  endtask

  // Checks outputs of the previous cycle, then drives the next inputs
  task automatic step(input bit v, input logic [3:0] op, input logic [1:0] es,
                      input logic [63:0] a, input logic [63:0] b);
    @(negedge clk_i);
    check_now();
    in_valid_i = v; op_i = op; esize_i = es; a_i = a; b_i = b;
    exp_valid = v;
    if (v) begin
      exp_res = model(op, es, a, b);
      exp_tag = tag_of(op);
      if (op <= 4'd6 && es == 2'd3) exp_tag = "R1";
    end else begin
      exp_tag = "R10";
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check_now(); // R9 reset state
    rst_ni = 1'b1;
    // R1: lane boundaries stop carries at every width
    step(1, 4'd0, 2'd0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001);
    step(1, 4'd0, 2'd1, 64'h00FF_FFFF_00FF_FFFF, 64'h0001_0001_0001_0001);
    step(1, 4'd0, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001);
    step(1, 4'd3, 2'd3, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001);
    // R2: wrap
    step(1, 4'd3, 2'd0, 64'h0001_0203_8000_7F00, 64'h0102_0304_0100_8001);
    // R3: signed limits
    step(1, 4'd1, 2'd0, 64'h7F80_7F80_0102_7FFF, 64'h0180_7F80_FEFE_0101);
    step(1, 4'd1, 2'd1, 64'h7FFF_8000_1234_FFFF, 64'h0001_FFFF_1234_FFFF);
    step(1, 4'd4, 2'd2, 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF);
    step(1, 4'd4, 2'd0, 64'h7F80_0080_7F00_1122, 64'h80FF_807F_8001_2211);
    // R4: unsigned limits
    step(1, 4'd2, 2'd0, 64'hFF80_0102_FFFE_7F7F, 64'h0180_FEFE_0001_8080);
    step(1, 4'd5, 2'd1, 64'h0000_0005_FFFF_8000, 64'h0001_0005_0001_8001);
    step(1, 4'd2, 2'd2, 64'hFFFF_FFFF_1000_0000, 64'h0000_0001_2000_0000);
    // R5: compare masks
    step(1, 4'd6, 2'd0, 64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788);
    step(1, 4'd6, 2'd1, 64'h1122_3344_5566_7788, 64'h1122_3345_5566_7788);
    step(1, 4'd6, 2'd2, 64'hDEAD_BEEF_0000_0000, 64'hDEAD_BEEF_0000_0001);
    // R6: logic ops, esize irrelevant
    step(1, 4'd7, 2'd0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_5555_AAAA);
    step(1, 4'd8, 2'd1, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_5555_AAAA);
    step(1, 4'd9, 2'd2, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_5555_AAAA);
    // R10: idle cycles hold
    step(0, 4'd0, 2'd0, 64'h1, 64'h1);
    step(0, 4'd9, 2'd2, 64'hFFFF, 64'h0);
    // R8: undefined opcodes
    for (int o = 10; o < 16; o++) step(1, 4'(o), 2'(o % 4), 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    // Mixed pseudo-random traffic (R7)
    for (int n = 0; n < 600; n++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = (n % 5 == 0) ? ra : {$urandom, $urandom};
      step((n % 7) != 3, 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)), ra, rb);
    end
    step(0, 4'd0, 2'd0, 64'h0, 64'h0);
    @(negedge clk_i);
    check_now();
    // R9: asynchronous reset clears outputs
    rst_ni = 1'b0;
    exp_res = '0; exp_valid = 0; exp_tag = "R9";
    #1;
    check_now();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule